// File: doc/BRIEF.md
# Shared Address / General-Purpose I/O Port Controller

This block controls an 8-pin port whose pins serve either as general-purpose I/O or as the upper bits of an external address bus. A small register interface (2-bit register select, write and read strobes, write and read data) reaches four registers. The first is a write-only direction register. The second is an output data register that can be read and written. The third is a read-only pin-state register, and the fourth is a pull-up enable register that can be read and written. A 2-bit operating-mode input decides, pin by pin, whether the pin is forced onto the address bus, is steered to the address bus or to input by its direction bit, or is steered to the data register or to input by its direction bit.

Two standby inputs are provided. Hardware standby releases every pin and clears the direction register. Software standby keeps all register contents. While software standby is active, a hold-enable input decides whether pins that carry address keep the last address they drove or release the line. The block produces, for each pin, an output enable, an output value and a pull-up enable. The pad itself and the CPU bus protocol lie outside the block.

Top module: `addr_gpio_port`

## Requirements
- R1: After reset the direction, data and pull-up registers hold 0x00. In mode code 3 every output enable and every pull-up enable is then 0, and reads of the data and pull-up registers return 0x00.
- R2: In mode codes 0 and 1, outside standby, all output enables are 1 and `pin_out_o` equals `ext_addr_i`, whatever the direction register holds.
- R3: In mode code 2, outside standby, a pin whose direction bit is 1 is enabled and drives its `ext_addr_i` bit. A pin whose direction bit is 0 is not enabled.
- R4: In mode code 3, outside standby, a pin whose direction bit is 1 is enabled and drives its data register bit. A pin whose direction bit is 0 is not enabled.
- R5: Register select codes are: 0 direction (write-only, read value undefined), 1 data, 2 pin state (read-only), 3 pull-up. A write takes effect at the clock edge where `bus_we_i` is high. `bus_rdata_o` is combinational and is 0 while `bus_re_i` is low.
- R6: A change on `pin_i` appears in a pin-state read after exactly two rising clock edges, and not after one.
- R7: `pin_pu_o[i]` is 1 exactly when `pin_oe_o[i]` is 0 and pull-up register bit i is 1.
- R8: `pin_out_o[i]` is 0 whenever `pin_oe_o[i]` is 0.
- R9: While `hw_stby_i` is 1 every output enable is 0 and the direction register is cleared to 0x00. The cleared value remains after standby ends.
- R10: In software standby with `hold_en_i` at 1, pins carrying address keep driving the address present on the cycle before standby began, even if `ext_addr_i` changes.
- R11: In software standby with `hold_en_i` at 0, pins carrying address have their output enable at 0. Pins driven from the data register in mode code 3 keep driving.
- R12: During either standby, writes to the direction, data and pull-up registers are ignored. After software standby the direction and data contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Operating mode code (0..3) |
| hw_stby_i | input | 1 | Hardware standby |
| sw_stby_i | input | 1 | Software standby |
| hold_en_i | input | 1 | Keep address outputs driven in software standby |
| bus_sel_i | input | 2 | Register select |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| ext_addr_i | input | 8 | Address bits to present on the port |
| pin_i | input | 8 | Pin levels from the pads |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_out_o | output | 8 | Per-pin output value |
| pin_pu_o | output | 8 | Per-pin pull-up enable |

## Verification
The hardest case to reach is address retention in software standby. The held value must be the address from the cycle before entry, and it must not follow `ext_addr_i` once standby is active. The stimulus sets a known address in an address mode, raises software standby with hold enabled on a falling edge, and then changes `ext_addr_i` across several clocks while watching the pins. It then drops hold enable to see the pins release, and switches to mode code 3 so that data-driven pins can be shown still driving. Writes are issued during standby, and the register contents are checked after exit to show those writes had no effect.

// File: rtl/addr_gpio_pkg.sv
package addr_gpio_pkg;
  typedef enum logic [1:0] {
    MODE_ADDR_A = 2'd0,
    MODE_ADDR_B = 2'd1,
    MODE_ADDR_SEL = 2'd2,
    MODE_GPIO = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SEL_DIR = 2'd0,
    SEL_DAT = 2'd1,
    SEL_PIN = 2'd2,
    SEL_PUL = 2'd3
  } sel_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/agp_sync.sv
module agp_sync #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/agp_regs.sv
module agp_regs
  import addr_gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] DIR_RD_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_stby_i,
  input  logic             sw_stby_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] dat_o,
  output logic [WIDTH-1:0] pul_o
);
  sel_e sel;
  logic wr_ok;

  assign sel   = sel_e'(sel_i);
  assign wr_ok = we_i && !hw_stby_i && !sw_stby_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
    end else if (hw_stby_i) begin
      dir_o <= '0;
    end else if (wr_ok && sel == SEL_DIR) begin
      dir_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_o <= '0;
      pul_o <= '0;
    end else if (wr_ok) begin
      if (sel == SEL_DAT) dat_o <= wdata_i;
      if (sel == SEL_PUL) pul_o <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (sel)
        SEL_DIR: rdata_o = DIR_RD_VAL; // write-only: fixed filler
        SEL_DAT: rdata_o = dat_o;
        SEL_PIN: rdata_o = pin_sync_i;
        SEL_PUL: rdata_o = pul_o;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/agp_pin_ctrl.sv
module agp_pin_ctrl
  import addr_gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             hw_stby_i,
  input  logic             sw_stby_i,
  input  logic             hold_en_i,
  input  logic [WIDTH-1:0] ext_addr_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] dat_i,
  input  logic [WIDTH-1:0] pul_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] pu_o
);
  logic [WIDTH-1:0] addr_q;
  logic [WIDTH-1:0] addr_src;
  logic             all_addr;

  // Track the live address outside software standby; freeze on entry.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (!sw_stby_i) addr_q <= ext_addr_i;
  end

  assign addr_src = sw_stby_i ? addr_q : ext_addr_i;
  assign all_addr = (mode_i == MODE_ADDR_A) || (mode_i == MODE_ADDR_B);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic is_addr, is_gpio, drive, src;
    assign is_addr = all_addr || (mode_i == MODE_ADDR_SEL && dir_i[i]);
    assign is_gpio = (mode_i == MODE_GPIO) && dir_i[i];
    assign drive   = !hw_stby_i &&
                     (is_gpio || (is_addr && (!sw_stby_i || hold_en_i)));
    assign src     = is_addr ? addr_src[i] : dat_i[i];
    assign oe_o[i]  = drive;
    assign out_o[i] = drive & src;
    assign pu_o[i]  = !drive & pul_i[i];
  end
endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
  import addr_gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             hw_stby_i,
  input  logic             sw_stby_i,
  input  logic             hold_en_i,
  input  logic [1:0]       bus_sel_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  output logic [WIDTH-1:0] bus_rdata_o,
  input  logic [WIDTH-1:0] ext_addr_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pin_pu_o
);
  logic [WIDTH-1:0] pin_sync, dir, dat, pul;

  agp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  agp_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_stby_i (hw_stby_i),
    .sw_stby_i (sw_stby_i),
    .sel_i     (bus_sel_i),
    .we_i      (bus_we_i),
    .re_i      (bus_re_i),
    .wdata_i   (bus_wdata_i),
    .pin_sync_i(pin_sync),
    .rdata_o   (bus_rdata_o),
    .dir_o     (dir),
    .dat_o     (dat),
    .pul_o     (pul)
  );

  agp_pin_ctrl #(.WIDTH(WIDTH)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_e'(mode_i)),
    .hw_stby_i (hw_stby_i),
    .sw_stby_i (sw_stby_i),
    .hold_en_i (hold_en_i),
    .ext_addr_i(ext_addr_i),
    .dir_i     (dir),
    .dat_i     (dat),
    .pul_i     (pul),
    .oe_o      (pin_oe_o),
    .out_o     (pin_out_o),
    .pu_o      (pin_pu_o)
  );
endmodule

// File: rtl/addr_gpio_port_chk.sv
module addr_gpio_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             hw_stby_i,
  input logic             sw_stby_i,
  input logic             hold_en_i,
  input logic [1:0]       bus_sel_i,
  input logic             bus_re_i,
  input logic [WIDTH-1:0] bus_rdata_o,
  input logic [WIDTH-1:0] ext_addr_i,
  input logic [WIDTH-1:0] pin_i,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic [WIDTH-1:0] pin_out_o,
  input logic [WIDTH-1:0] pin_pu_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_addr_modes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_stby_i && !sw_stby_i && mode_i[1] == 1'b0)
      |-> (pin_oe_o == '1 && pin_out_o == ext_addr_i));

  p_pin_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && bus_re_i && bus_sel_i == 2'd2)
      |-> bus_rdata_o == $past(pin_i, 2));

  p_pu_only_input_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pu_o & pin_oe_o) == '0);

  p_out_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0);

  p_hw_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |-> pin_oe_o == '0);

  p_hw_dir_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && $past(hw_stby_i) && !hw_stby_i && !sw_stby_i && mode_i == 2'd3)
      |-> pin_oe_o == '0);

  p_hold_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && sw_stby_i && $past(sw_stby_i) && hold_en_i && $past(hold_en_i)
     && !hw_stby_i && !$past(hw_stby_i) && mode_i[1] == 1'b0 && $stable(mode_i))
      |-> $stable(pin_out_o));

  p_no_hold_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stby_i && !hold_en_i && mode_i[1] == 1'b0) |-> pin_oe_o == '0);
endmodule

bind addr_gpio_port addr_gpio_port_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .hw_stby_i  (hw_stby_i),
  .sw_stby_i  (sw_stby_i),
  .hold_en_i  (hold_en_i),
  .bus_sel_i  (bus_sel_i),
  .bus_re_i   (bus_re_i),
  .bus_rdata_o(bus_rdata_o),
  .ext_addr_i (ext_addr_i),
  .pin_i      (pin_i),
  .pin_oe_o   (pin_oe_o),
  .pin_out_o  (pin_out_o),
  .pin_pu_o   (pin_pu_o)
);

// File: tb/addr_gpio_port_tb_top.sv
module addr_gpio_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'd3;
  logic         hw = 1'b0, sw = 1'b0, hold = 1'b0;
  logic [1:0]   sel = '0;
  logic         we = 1'b0, re = 1'b0;
  logic [W-1:0] wdata = '0, ext = '0, pins = '0;
  logic [W-1:0] rdata, oe, out, pu;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_gpio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .hw_stby_i(hw), .sw_stby_i(sw), .hold_en_i(hold),
    .bus_sel_i(sel), .bus_we_i(we), .bus_re_i(re),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ext_addr_i(ext), .pin_i(pins),
    .pin_oe_o(oe), .pin_out_o(out), .pin_pu_o(pu)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    sel = s; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] d);
    @(negedge clk);
    sel = s; re = 1'b1;
    #1 d = rdata;
    re = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    mode = 2'd3; #1;
    chk("R1", "oe after reset", oe, 8'h00);
    chk("R1", "pu after reset", pu, 8'h00);
    rd(2'd1, d); chk("R1", "data reg reset", d, 8'h00);
    rd(2'd3, d); chk("R1", "pull reg reset", d, 8'h00);
  endtask

  task automatic t_gpio();
    logic [W-1:0] d;
    wr(2'd0, 8'hF0);
    wr(2'd1, 8'hA5);
    chk("R4", "gpio oe", oe, 8'hF0);
    chk("R4", "gpio out", out, 8'hA0);
    chk("R8", "out low on inputs", out & ~oe, 8'h00);
    wr(2'd3, 8'h3C);
    chk("R7", "pull only on inputs", pu, 8'h0C);
    rd(2'd1, d); chk("R5", "data readback", d, 8'hA5);
    rd(2'd3, d); chk("R5", "pull readback", d, 8'h3C);
    sel = 2'd1; #1;
    chk("R5", "rdata idle", rdata, 8'h00);
  endtask

  task automatic t_addr_modes();
    ext = 8'h5A; mode = 2'd2; #1;
    chk("R3", "mode2 oe", oe, 8'hF0);
    chk("R3", "mode2 out", out, 8'h50);
    chk("R7", "mode2 pu", pu, 8'h0C);
    mode = 2'd0; #1;
    chk("R2", "mode0 oe", oe, 8'hFF);
    chk("R2", "mode0 out", out, 8'h5A);
    chk("R7", "mode0 pu", pu, 8'h00);
    mode = 2'd1; ext = 8'hC3; #1;
    chk("R2", "mode1 out", out, 8'hC3);
    chk("R2", "mode1 oe", oe, 8'hFF);
  endtask

  task automatic t_pin_sync();
    logic [W-1:0] d;
    @(negedge clk); pins = 8'h96;
    @(posedge clk);
    rd(2'd2, d); chk("R6", "pin state after one edge", d, 8'h00);
    rd(2'd2, d); chk("R6", "pin state after two edges", d, 8'h96);
  endtask

  task automatic t_sw_standby();
    logic [W-1:0] d;
    @(negedge clk); mode = 2'd0; ext = 8'h33;
    @(negedge clk); sw = 1'b1; hold = 1'b1; #1;
    chk("R10", "held addr on entry", out, 8'h33);
    ext = 8'hCC;
    settle(); settle();
    chk("R10", "held addr after change", out, 8'h33);
    chk("R10", "held oe", oe, 8'hFF);
    hold = 1'b0; #1;
    chk("R11", "addr pins released", oe, 8'h00);
    mode = 2'd3; #1;
    chk("R11", "gpio still driven oe", oe, 8'hF0);
    chk("R11", "gpio still driven out", out, 8'hA0);
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h00);
    @(negedge clk); sw = 1'b0; #1;
    chk("R12", "dir kept after sw standby", oe, 8'hF0);
    chk("R12", "data kept out", out, 8'hA0);
    rd(2'd1, d); chk("R12", "data reg unchanged", d, 8'hA5);
    rd(2'd3, d); chk("R12", "pull reg unchanged", d, 8'h3C);
  endtask

  task automatic t_hw_standby();
    logic [W-1:0] d;
    @(negedge clk); mode = 2'd0; hw = 1'b1; #1;
    chk("R9", "hw oe mode0", oe, 8'h00);
    chk("R8", "hw out", out, 8'h00);
    chk("R7", "hw pu", pu, 8'h3C);
    mode = 2'd3;
    wr(2'd1, 8'h11);
    @(negedge clk); hw = 1'b0; #1;
    chk("R9", "dir cleared by hw", oe, 8'h00);
    rd(2'd1, d); chk("R12", "write in hw ignored", d, 8'hA5);
    wr(2'd0, 8'h81);
    chk("R5", "dir write after hw", oe, 8'h81);
    chk("R4", "out after hw", out, 8'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_gpio();
    t_addr_modes();
    t_pin_sync();
    t_sw_standby();
    t_hw_standby();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule